// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block holds the software-visible state of one general-purpose I/O port of sixteen pins. Three registers sit behind a simple word-addressed register bus with separate read and write strobes. The mode register gives every pin a 2-bit mode. The data register holds the level the port drives. The pull register holds one pull-up enable bit per pin. The block drives the stored data levels, a per-pin output enable derived from the modes, and the pull-up enables toward the pad logic.

A write to the data register is gated pin by pin. Only pins whose mode field selects output take the new bit, and every other bit keeps its stored value. Two designated pins carry the lines of an open-drain two-wire bus. While such a pin is in input mode, a read of the data register returns 1 for it, so an idle bus looks released to software. This forcing exists only on the read path. The stored bit is never altered by it.

Read data is registered and returned one cycle after the read strobe, together with a one-cycle valid pulse. The bus has no back-pressure: a strobe is accepted in the cycle it is high, and the bus cannot stall.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the mode, data and pull registers are 0, so `pin_out`, `pin_oe` and `pin_pull` are 0 and `bus_rvalid` is low.
- R2: Byte address 0x00 selects the mode register, 0x04 the data register and 0x08 the pull register. Address bits [1:0] are ignored. The pull register keeps bits [15:0] of a write and reads back zero-extended to 32 bits.
- R3: The mode of pin n lives in mode register bits [2n+1:2n]. Code 01 is output mode, code 00 is input mode, and codes 10 and 11 are neither. `pin_oe[n]` is 1 exactly when field n holds 01.
- R4: On a data-register write, bit n takes `bus_wdata[n]` only if pin n is in output mode. All other data bits keep their previous value.
- R5: A read of the data register returns 1 in bits 14 and 15 when that pin's mode field (bits [29:28] for pin 14, bits [31:30] for pin 15) is 00. Every other bit returns the stored value, and bits [31:16] return 0.
- R6: The forced-high read value never changes the stored data. `pin_out` always equals the stored data register.
- R7: A write to any byte address whose word index is 3 or above changes no register, and a read from such an address returns 0.
- R8: `bus_rdata` and a one-cycle `bus_rvalid` pulse appear in the cycle after `bus_rd`. The returned word reflects register state before any write accepted in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for the one cycle in which bus_rdata is valid |
| pin_out | output | 16 | Stored data levels toward the pads |
| pin_oe | output | 16 | Per-pin output enable (mode 01) |
| pin_pull | output | 16 | Per-pin pull-up enable |

## Verification
A read and a write can be accepted in the same cycle. This is the case that decides the ordering rules. The bench raises both strobes on the same edge against the data register, and separately against the pull register. It expects the returned word to hold the contents from before the write, with the forced-high bits computed from the old mode. A second, plain read must then show the new, mode-gated contents. Writes to the mode register are interleaved with data reads so that forcing follows the mode, while `pin_out` shows the stored bits beneath it unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'b00,
    MODE_OUTPUT = 2'b01,
    MODE_ALT    = 2'b10,
    MODE_RSVD   = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned WORD_MODE = 0;
  localparam int unsigned WORD_DATA = 1;
  localparam int unsigned WORD_PULL = 2;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic [1:0]       byte_lane;

  // the low two address bits pick a byte lane, which this bank ignores
  assign word_idx  = addr[ADDR_W-1:2];
  assign byte_lane = addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    if (word_idx == IDX_W'(WORD_MODE))      sel = SEL_MODE;
    else if (word_idx == IDX_W'(WORD_DATA)) sel = SEL_DATA;
    else if (word_idx == IDX_W'(WORD_PULL)) sel = SEL_PULL;
    else if (byte_lane == 2'b11)            sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic [PINS*MODE_W-1:0] mode_q,
  output logic [PINS-1:0]        out_mask,
  output logic [PINS-1:0]        idle_mask
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    pin_mode_e field;
    assign field        = pin_mode_e'(mode_q[g*MODE_W +: MODE_W]);
    assign out_mask[g]  = (field == MODE_OUTPUT);
    assign idle_mask[g] = (field == MODE_INPUT);
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  reg_sel_e               sel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [PINS-1:0]        out_mask,
  output logic [PINS*MODE_W-1:0] mode_q,
  output logic [PINS-1:0]        data_q,
  output logic [PINS-1:0]        pull_q
);
  localparam int unsigned MODE_BITS = PINS * MODE_W;

  logic [PINS-1:0] data_merged;

  // gated merge: clear the output-mode bits, then OR in the new ones
  assign data_merged = (data_q & ~out_mask) | (wdata[PINS-1:0] & out_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      data_q <= '0;
      pull_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_MODE: mode_q <= wdata[MODE_BITS-1:0];
        SEL_DATA: data_q <= data_merged;
        SEL_PULL: pull_q <= wdata[PINS-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
  import gpio_bank_pkg::*;
#(
  parameter int unsigned     PINS       = 16,
  parameter int unsigned     DATA_W     = 32,
  parameter logic [PINS-1:0] FORCE_MASK = 16'hC000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  reg_sel_e               sel,
  input  logic [PINS*MODE_W-1:0] mode_q,
  input  logic [PINS-1:0]        data_q,
  input  logic [PINS-1:0]        pull_q,
  input  logic [PINS-1:0]        idle_mask,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rvalid
);
  logic [PINS-1:0]   data_view;
  logic [DATA_W-1:0] rdata_d;

  // bus lines in input mode read back as released; storage untouched
  assign data_view = data_q | (FORCE_MASK & idle_mask);

  always_comb begin
    unique case (sel)
      SEL_MODE: rdata_d = DATA_W'(mode_q);
      SEL_DATA: rdata_d = DATA_W'(data_view);
      SEL_PULL: rdata_d = DATA_W'(pull_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned     PINS       = 16,
  parameter int unsigned     ADDR_W     = 8,
  parameter int unsigned     DATA_W     = 32,
  parameter logic [PINS-1:0] FORCE_MASK = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_pull
);
  localparam int unsigned MODE_BITS = PINS * MODE_W;

  reg_sel_e               sel;
  logic [MODE_BITS-1:0]   mode_q;
  logic [PINS-1:0]        data_q;
  logic [PINS-1:0]        pull_q;
  logic [PINS-1:0]        out_mask;
  logic [PINS-1:0]        idle_mask;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_mode_decode #(.PINS(PINS)) u_mode (
    .mode_q    (mode_q),
    .out_mask  (out_mask),
    .idle_mask (idle_mask)
  );

  gpio_reg_file #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .out_mask (out_mask),
    .mode_q   (mode_q),
    .data_q   (data_q),
    .pull_q   (pull_q)
  );

  gpio_read_path #(.PINS(PINS), .DATA_W(DATA_W), .FORCE_MASK(FORCE_MASK)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .sel       (sel),
    .mode_q    (mode_q),
    .data_q    (data_q),
    .pull_q    (pull_q),
    .idle_mask (idle_mask),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  assign pin_out  = data_q;
  assign pin_oe   = out_mask;
  assign pin_pull = pull_q;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int unsigned     PINS       = 16,
  parameter int unsigned     ADDR_W     = 8,
  parameter int unsigned     DATA_W     = 32,
  parameter logic [PINS-1:0] FORCE_MASK = 16'hC000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bus_rvalid,
  input logic [PINS-1:0]     pin_out,
  input logic [PINS-1:0]     pin_oe,
  input logic [PINS-1:0]     pin_pull,
  input logic [PINS*2-1:0]   mode_q
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic is_mode, is_data, is_pull, is_bad;
  assign idx     = bus_addr[ADDR_W-1:2];
  assign is_mode = (idx == IDX_W'(0));
  assign is_data = (idx == IDX_W'(1));
  assign is_pull = (idx == IDX_W'(2));
  assign is_bad  = !(is_mode || is_data || is_pull);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0 && pin_pull == '0 && !bus_rvalid));

  p_oe_only_on_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_mode) |=> $stable(pin_oe));

  p_gated_data_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_data) |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  p_data_only_on_data_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_data) |=> $stable(pin_out));

  p_bad_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_bad) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pull)));

  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_bad) |=> (bus_rdata == '0));

  p_rvalid_follows_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_read_old_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_pull) |=> (bus_rdata == DATA_W'($past(pin_pull))));

  for (genvar g = 0; g < PINS; g++) begin : g_force
    if (FORCE_MASK[g]) begin : g_on
      p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_data && mode_q[2*g+1 -: 2] == 2'b00) |=> bus_rdata[g]);
    end
  end
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
  .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FORCE_MASK(FORCE_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_pull   (pin_pull),
  .mode_q     (mode_q)
);

// File: tb/test_gpio_port_bank.sv
`timescale 1ns/1ps
module test_gpio_port_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] pin_out, pin_oe, pin_pull;

  int checks = 0;
  int errors = 0;

  // bench-side model of register contents
  logic [31:0] m_mode = '0;
  logic [15:0] m_data = '0;
  logic [15:0] m_pull = '0;

  always #2.5 clk = ~clk;

  gpio_port_bank i_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull(pin_pull)
  );

  function automatic logic [15:0] oe_of(input logic [31:0] m);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (m[2*i +: 2] == 2'b01);
    return r;
  endfunction

  function automatic logic [31:0] data_read_of(input logic [31:0] m, input logic [15:0] d);
    logic [15:0] v = d;
    if (m[29:28] == 2'b00) v[14] = 1'b1;
    if (m[31:30] == 2'b00) v[15] = 1'b1;
    return {16'h0, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    check("R8 rvalid", {31'h0, bus_rvalid}, 32'h1);
  endtask

  task automatic set_mode(input logic [31:0] m);
    wr(8'h00, m); m_mode = m;
  endtask

  task automatic put_data(input logic [15:0] d);
    logic [15:0] oe = oe_of(m_mode);
    wr(8'h04, {16'hDEAD, d});
    m_data = (m_data & ~oe) | (d & oe);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_pull", {16'h0, pin_pull}, 32'h0);
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    rd(8'h00, v); check("R1 mode read", v, 32'h0);
    rd(8'h08, v); check("R1 pull read", v, 32'h0);
    rd(8'h04, v); check("R5 reset data read forced", v, 32'h0000_C000);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    set_mode(32'h5555_5555);
    check("R3 all output", {16'h0, pin_oe}, 32'h0000_FFFF);
    set_mode(32'h1E4B_9C61);
    check("R3 mixed modes", {16'h0, pin_oe}, {16'h0, oe_of(32'h1E4B_9C61)});
    rd(8'h00, v); check("R2 mode readback", v, 32'h1E4B_9C61);
    set_mode(32'hAAAA_FFFF);
    check("R3 codes 10/11 not output", {16'h0, pin_oe}, 32'h0);
  endtask

  task automatic t_gated_write();
    logic [31:0] v;
    set_mode(32'h0000_5555);
    put_data(16'hFFFF);
    check("R4 low pins written", {16'h0, pin_out}, 32'h0000_00FF);
    set_mode(32'h5555_0000);
    put_data(16'h1234);
    check("R4 high pins only", {16'h0, pin_out}, 32'h0000_12FF);
    rd(8'h04, v); check("R4 data readback", v, data_read_of(m_mode, m_data));
    set_mode(32'hAAAA_AAAA);
    put_data(16'h0000);
    check("R4 alt mode blocks write", {16'h0, pin_out}, 32'h0000_12FF);
  endtask

  task automatic t_force();
    logic [31:0] v;
    set_mode(32'h5555_5555);
    put_data(16'h0000);
    set_mode(32'h0555_5555);
    rd(8'h04, v); check("R5 both bus pins forced", v, 32'h0000_C000);
    check("R6 stored bits untouched", {16'h0, pin_out}, 32'h0);
    set_mode(32'h3555_5555);
    rd(8'h04, v); check("R5 mode 11 not forced", v, 32'h0000_8000);
    set_mode(32'h5555_5555);
    rd(8'h04, v); check("R6 output mode shows stored", v, 32'h0);
  endtask

  task automatic t_pull_and_lanes();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_A5A5); m_pull = 16'hA5A5;
    check("R2 pull pins", {16'h0, pin_pull}, 32'h0000_A5A5);
    rd(8'h0B, v); check("R2 pull zero-extended", v, 32'h0000_A5A5);
    wr(8'h05, 32'h0000_0F0F); m_data = 16'h0F0F;
    check("R2 byte lane ignored", {16'h0, pin_out}, 32'h0000_0F0F);
  endtask

  task automatic t_bad_addr();
    logic [31:0] v;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0000);
    wr(8'hFC, 32'h1234_5678);
    check("R7 data kept", {16'h0, pin_out}, {16'h0, m_data});
    check("R7 oe kept", {16'h0, pin_oe}, {16'h0, oe_of(m_mode)});
    check("R7 pull kept", {16'h0, pin_pull}, {16'h0, m_pull});
    rd(8'h00, v); check("R7 mode kept", v, m_mode);
    rd(8'h0C, v); check("R7 bad read zero", v, 32'h0);
    rd(8'hFC, v); check("R7 top read zero", v, 32'h0);
  endtask

  task automatic t_overlap();
    logic [31:0] v, old;
    old = data_read_of(m_mode, m_data);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_3C3C;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R8 same-cycle read old data", bus_rdata, old);
    check("R8 pulse", {31'h0, bus_rvalid}, 32'h1);
    m_data = (m_data & ~oe_of(m_mode)) | (16'h3C3C & oe_of(m_mode));
    @(negedge clk);
    check("R8 pulse one cycle", {31'h0, bus_rvalid}, 32'h0);
    rd(8'h04, v); check("R8 later read new data", v, data_read_of(m_mode, m_data));
    old = {16'h0, m_pull};
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0000_0001;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; m_pull = 16'h0001;
    check("R8 same-cycle read old pull", bus_rdata, old);
    rd(8'h08, v); check("R8 later read new pull", v, 32'h0000_0001);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_before_release();
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_gated_write();
    t_force();
    t_pull_and_lanes();
    t_bad_addr();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_before_release();
    check("R1 oe in reset", {16'h0, pin_oe}, 32'h0);
  endtask
endmodule